// File: doc/BRIEF.md
# Event-to-Virtual-Interrupt Aggregator

This block gathers a bank of single-bit event inputs onto a small number of virtual interrupt lines. A routing table, written over the register port, sends each event number to one slot: a virtual interrupt and one of its 64 bit positions. Each slot is either edge-type or level-type. An edge-type slot latches a rising edge of its source until software clears it. A level-type slot copies the source level. Each virtual interrupt has a 64-bit enable vector, and it drives an active-high level output while any enabled status bit is set.

Software reaches the block through a single-cycle 64-bit register port. Each virtual interrupt has its own 4 KiB page. The page holds set-enable and clear-enable registers, a raw status register that clears edge bits when written with ones, and a read-only masked status view. Routing entries sit in a separate window. A saturating counter records the rising edges that arrive on events with no valid route.

The port runs a two-state machine. PORT_IDLE is the rest state and the reset state. An accepted read moves it to PORT_RESP, where read data is presented. From PORT_RESP, another read keeps it in PORT_RESP, and anything else returns it to PORT_IDLE. Writes take effect at the clock edge where they are accepted and never leave PORT_IDLE.

Top module: `evagg_top`

## Requirements
- R1: After reset, all enable and status bits, all routing entries, the drop counter and every irq output are zero.
- R2: Writing page offset 0x000 sets each enable bit written as 1 and leaves the others unchanged. Offsets 0x000 and 0x008 both read back the enable vector.
- R3: Writing page offset 0x008 clears each enable bit written as 1 and leaves the others unchanged.
- R4: A rising edge (low in one cycle, high in the next) on an event routed to an edge-type slot sets that status bit at the next clock edge. Raw status reads at page offset 0x018.
- R5: Writing ones to offset 0x018 clears those edge-type status bits. Bits written as 0 stay unchanged.
- R6: When a rising edge and a clearing write hit the same edge-type bit in the same cycle, the bit ends up set.
- R7: Offset 0x020 reads raw status ANDed with enable. Writes to it change neither status nor enable.
- R8: A level-type slot's status bit equals its source level from the previous cycle. Clearing writes do not affect it.
- R9: irq_out[v] is high exactly when virtual interrupt v has a status bit set whose enable bit is also set.
- R10: The routing entry for event e is at address 0x8000 + 8*e. Its fields are: bit 0 valid, bit 1 level mode, bits 13:8 slot, bits 18:16 virtual interrupt. It reads back as written, and writing valid = 0 removes the route.
- R11: A rising edge on an event with no valid route changes no status bit. It adds one to a drop counter read at 0xC000, and the counter saturates at its maximum value.
- R12: Virtual interrupt v has its page at v*0x1000. An event routed to one virtual interrupt leaves every other virtual interrupt's status unchanged.
- R13: Read data appears on bus_rdata with bus_rvalid high in the cycle after the read is accepted. bus_rvalid is low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | NUM_EVT | Event inputs, indexed by event number |
| bus_en | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| irq_out | output | NUM_VINT | Active-high virtual interrupt lines |

## Verification
Two functions can fall in the same cycle: an edge-type slot being set by its source, and the same slot being cleared by a write of ones to raw status. The bench drives the event's rising edge in the same cycle as the clearing write, with the bit already set beforehand, so the bit survives only if the set takes priority. A later raw status read must show the bit still set. The same collision on a level-type slot is provoked by writing all ones to raw status while the source is held high, and the level bit must stay set while the edge bits clear.

// File: rtl/evagg_pkg.sv
package evagg_pkg;

    localparam int SLOTS  = 64;
    localparam int SLOT_W = 6;
    localparam int PAGE_W = 3;

    localparam logic [11:0] OFF_EN_SET = 12'h000;
    localparam logic [11:0] OFF_EN_CLR = 12'h008;
    localparam logic [11:0] OFF_RAW    = 12'h018;
    localparam logic [11:0] OFF_MASKED = 12'h020;
    localparam logic [15:0] CNT_ADDR   = 16'hC000;

    typedef struct packed {
        logic [PAGE_W-1:0] vint;
        logic [SLOT_W-1:0] slot;
        logic              level;
        logic              valid;
    } route_t;

    typedef enum logic {
        PORT_IDLE,
        PORT_RESP
    } port_st_e;

    function automatic logic [63:0] route_to_word(input route_t r);
        logic [63:0] w;
        w        = '0;
        w[0]     = r.valid;
        w[1]     = r.level;
        w[13:8]  = r.slot;
        w[18:16] = r.vint;
        return w;
    endfunction

    function automatic route_t word_to_route(input logic [63:0] w);
        route_t r;
        r.valid = w[0];
        r.level = w[1];
        r.slot  = w[13:8];
        r.vint  = w[18:16];
        return r;
    endfunction

endpackage

// File: rtl/evagg_route.sv
module evagg_route
    import evagg_pkg::*;
#(
    parameter int NUM_EVT  = 16,
    parameter int NUM_VINT = 4,
    parameter int CNT_W    = 8,
    localparam int EVT_W   = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1,
    localparam int VW      = (NUM_VINT > 1) ? $clog2(NUM_VINT) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_EVT-1:0]               evt_in,
    input  logic                             map_we,
    input  logic [EVT_W-1:0]                 map_idx,
    input  route_t                           map_wr,
    output route_t [NUM_EVT-1:0]             map_tbl,
    output logic [NUM_VINT-1:0][SLOTS-1:0]   edge_set,
    output logic [NUM_VINT-1:0][SLOTS-1:0]   lvl_own,
    output logic [NUM_VINT-1:0][SLOTS-1:0]   lvl_val,
    output logic [CNT_W-1:0]                 drop_cnt
);

    localparam int unsigned CNT_MAX = (1 << CNT_W) - 1;

    logic [NUM_EVT-1:0] evt_q;
    logic [NUM_EVT-1:0] rise;
    logic [NUM_EVT-1:0] drop;
    logic [CNT_W-1:0]   cnt_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= evt_in;
    end

    assign rise = evt_in & ~evt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_tbl <= '0;
        end else if (map_we) begin
            map_tbl[map_idx] <= map_wr;
        end
    end

    always_comb begin
        logic [VW-1:0] vi;
        logic          ok;
        edge_set = '0;
        lvl_own  = '0;
        lvl_val  = '0;
        drop     = '0;
        for (int e = 0; e < NUM_EVT; e++) begin
            vi = map_tbl[e].vint[VW-1:0];
            ok = map_tbl[e].valid && ({1'b0, map_tbl[e].vint} < 4'(NUM_VINT));
            if (!ok) begin
                drop[e] = rise[e];
            end else if (map_tbl[e].level) begin
                lvl_own[vi][map_tbl[e].slot] = 1'b1;
                if (evt_in[e]) lvl_val[vi][map_tbl[e].slot] = 1'b1;
            end else if (rise[e]) begin
                edge_set[vi][map_tbl[e].slot] = 1'b1;
            end
        end
    end

    always_comb begin
        int unsigned sum;
        sum = int'(drop_cnt) + $countones(drop);
        cnt_next = (sum > CNT_MAX) ? CNT_W'(CNT_MAX) : CNT_W'(sum);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) drop_cnt <= '0;
        else        drop_cnt <= cnt_next;
    end

    // R11
    drop_cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> drop_cnt >= $past(drop_cnt));

    // R10
    map_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        map_we |=> map_tbl[$past(map_idx)] == $past(map_wr));

endmodule

// File: rtl/evagg_vint.sv
module evagg_vint
    import evagg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SLOTS-1:0] en_set,
    input  logic [SLOTS-1:0] en_clr,
    input  logic [SLOTS-1:0] w1c,
    input  logic [SLOTS-1:0] edge_set,
    input  logic [SLOTS-1:0] lvl_own,
    input  logic [SLOTS-1:0] lvl_val,
    output logic [SLOTS-1:0] enable,
    output logic [SLOTS-1:0] status,
    output logic             irq
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable <= '0;
            status <= '0;
        end else begin
            enable <= (enable | en_set) & ~en_clr;
            status <= (lvl_own & lvl_val)
                    | (~lvl_own & ((status & ~w1c) | edge_set));
        end
    end

    assign irq = |(status & enable);

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_set & ~lvl_own) != '0 |=>
            (status & $past(edge_set & ~lvl_own)) == $past(edge_set & ~lvl_own));

    // R5
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c & ~edge_set & ~lvl_own) != '0 |=>
            (status & $past(w1c & ~edge_set & ~lvl_own)) == '0);

    // R8
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_own != '0 |=> (status & $past(lvl_own)) == $past(lvl_val & lvl_own));

    // R2
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_set != '0 && en_clr == '0) |=> (enable & $past(en_set)) == $past(en_set));

    // R3
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr != '0 |=> (enable & $past(en_clr)) == '0);

endmodule

// File: rtl/evagg_regif.sv
module evagg_regif
    import evagg_pkg::*;
#(
    parameter int NUM_EVT  = 16,
    parameter int NUM_VINT = 4,
    parameter int CNT_W    = 8,
    localparam int EVT_W   = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1,
    localparam int VW      = (NUM_VINT > 1) ? $clog2(NUM_VINT) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             bus_en,
    input  logic                             bus_we,
    input  logic [15:0]                      bus_addr,
    input  logic [63:0]                      bus_wdata,
    input  logic [NUM_VINT-1:0][SLOTS-1:0]   enable_all,
    input  logic [NUM_VINT-1:0][SLOTS-1:0]   status_all,
    input  route_t [NUM_EVT-1:0]             map_tbl,
    input  logic [CNT_W-1:0]                 drop_cnt,
    output logic [NUM_VINT-1:0][SLOTS-1:0]   en_set,
    output logic [NUM_VINT-1:0][SLOTS-1:0]   en_clr,
    output logic [NUM_VINT-1:0][SLOTS-1:0]   w1c,
    output logic                             map_we,
    output logic [EVT_W-1:0]                 map_idx,
    output route_t                           map_wr,
    output logic [63:0]                      bus_rdata,
    output logic                             bus_rvalid
);

    port_st_e          st_q, st_d;
    logic [PAGE_W-1:0] page;
    logic [11:0]       off;
    logic              page_ok;
    logic [10:0]       ent;
    logic              ent_ok;
    logic              cnt_hit;
    logic              rd_req, wr_req;
    logic [63:0]       rd_mux;

    assign rd_req  = bus_en && !bus_we;
    assign wr_req  = bus_en &&  bus_we;
    assign page    = bus_addr[14:12];
    assign off     = bus_addr[11:0];
    assign page_ok = !bus_addr[15] && ({1'b0, page} < 4'(NUM_VINT));
    assign ent     = bus_addr[13:3];
    assign ent_ok  = bus_addr[15] && !bus_addr[14] && (bus_addr[2:0] == 3'b000)
                     && ({1'b0, ent} < 12'(NUM_EVT));
    assign cnt_hit = (bus_addr == CNT_ADDR);

    // write decode
    always_comb begin
        en_set = '0;
        en_clr = '0;
        w1c    = '0;
        for (int v = 0; v < NUM_VINT; v++) begin
            if (wr_req && page_ok && page == PAGE_W'(v)) begin
                unique case (off)
                    OFF_EN_SET: en_set[v] = bus_wdata;
                    OFF_EN_CLR: en_clr[v] = bus_wdata;
                    OFF_RAW:    w1c[v]    = bus_wdata;
                    default:    ;
                endcase
            end
        end
    end

    assign map_we  = wr_req && ent_ok;
    assign map_idx = ent[EVT_W-1:0];
    assign map_wr  = word_to_route(bus_wdata);

    // read select
    always_comb begin
        rd_mux = '0;
        if (page_ok) begin
            unique case (off)
                OFF_EN_SET, OFF_EN_CLR: rd_mux = enable_all[page[VW-1:0]];
                OFF_RAW:    rd_mux = status_all[page[VW-1:0]];
                OFF_MASKED: rd_mux = status_all[page[VW-1:0]] & enable_all[page[VW-1:0]];
                default:    rd_mux = '0;
            endcase
        end else if (ent_ok) begin
            rd_mux = route_to_word(map_tbl[ent[EVT_W-1:0]]);
        end else if (cnt_hit) begin
            rd_mux = 64'(drop_cnt);
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= PORT_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PORT_IDLE: if (rd_req) st_d = PORT_RESP;
            PORT_RESP: st_d = rd_req ? PORT_RESP : PORT_IDLE;
            default:   st_d = PORT_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (rd_req) bus_rdata <= rd_mux;
    end

    assign bus_rvalid = (st_q == PORT_RESP);

    // R13
    rvalid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(rd_req));

    // R13
    read_gives_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> bus_rvalid);

endmodule

// File: rtl/evagg_top.sv
module evagg_top
    import evagg_pkg::*;
#(
    parameter int NUM_EVT  = 16,
    parameter int NUM_VINT = 4,
    parameter int CNT_W    = 8,
    localparam int EVT_W   = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_EVT-1:0]  evt_in,
    input  logic                bus_en,
    input  logic                bus_we,
    input  logic [15:0]         bus_addr,
    input  logic [63:0]         bus_wdata,
    output logic [63:0]         bus_rdata,
    output logic                bus_rvalid,
    output logic [NUM_VINT-1:0] irq_out
);

    logic [NUM_VINT-1:0][SLOTS-1:0] en_set, en_clr, w1c;
    logic [NUM_VINT-1:0][SLOTS-1:0] edge_set, lvl_own, lvl_val;
    logic [NUM_VINT-1:0][SLOTS-1:0] enable_all, status_all;
    route_t [NUM_EVT-1:0]           map_tbl;
    logic                           map_we;
    logic [EVT_W-1:0]               map_idx;
    route_t                         map_wr;
    logic [CNT_W-1:0]               drop_cnt;

    evagg_route #(.NUM_EVT(NUM_EVT), .NUM_VINT(NUM_VINT), .CNT_W(CNT_W)) u_route (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
        .map_we(map_we), .map_idx(map_idx), .map_wr(map_wr), .map_tbl(map_tbl),
        .edge_set(edge_set), .lvl_own(lvl_own), .lvl_val(lvl_val),
        .drop_cnt(drop_cnt)
    );

    evagg_regif #(.NUM_EVT(NUM_EVT), .NUM_VINT(NUM_VINT), .CNT_W(CNT_W)) u_regif (
        .clk(clk), .rst_n(rst_n),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .enable_all(enable_all), .status_all(status_all),
        .map_tbl(map_tbl), .drop_cnt(drop_cnt),
        .en_set(en_set), .en_clr(en_clr), .w1c(w1c),
        .map_we(map_we), .map_idx(map_idx), .map_wr(map_wr),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
    );

    for (genvar v = 0; v < NUM_VINT; v++) begin : g_vint
        evagg_vint u_vint (
            .clk(clk), .rst_n(rst_n),
            .en_set(en_set[v]), .en_clr(en_clr[v]), .w1c(w1c[v]),
            .edge_set(edge_set[v]), .lvl_own(lvl_own[v]), .lvl_val(lvl_val[v]),
            .enable(enable_all[v]), .status(status_all[v]), .irq(irq_out[v])
        );

        // R9
        irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
            irq_out[v] == ((status_all[v] & enable_all[v]) != '0));
    end

endmodule

// File: tb/sim_evagg_top.sv
module sim_evagg_top;

    localparam int NE = 16;
    localparam int NV = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NE-1:0] evt_in = '0;
    logic          bus_en = 1'b0;
    logic          bus_we = 1'b0;
    logic [15:0]   bus_addr = '0;
    logic [63:0]   bus_wdata = '0;
    logic [63:0]   bus_rdata;
    logic          bus_rvalid;
    logic [NV-1:0] irq_out;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [63:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    evagg_top #(.NUM_EVT(NE), .NUM_VINT(NV), .CNT_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq_out(irq_out)
    );

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [63:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [63:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        it.exp = exp; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic pulse(input int e);
        @(negedge clk);
        evt_in[e] = 1'b1;
        @(negedge clk);
        evt_in[e] = 1'b0;
    endtask

    task automatic chk_irq(input logic [NV-1:0] exp, input string tag);
        @(negedge clk);
        check(irq_out == exp, tag, 64'(irq_out), 64'(exp));
    endtask

    function automatic logic [63:0] ent(input int vint, input int slot, input bit lvl);
        return 64'(1) | (64'(lvl) << 1) | (64'(slot) << 8) | (64'(vint) << 16);
    endfunction

    // monitor: pops expected read data as responses appear
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R13 unexpected rvalid", bus_rdata, 64'h0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(bus_rdata === it.exp, it.tag, bus_rdata, it.exp);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_irq(4'b0000, "R1 irq after reset");
        rd(16'h1000, 64'h0, "R1 enable reset");
        rd(16'h1018, 64'h0, "R1 status reset");
        rd(16'h8018, 64'h0, "R1 map entry reset");
        rd(16'hC000, 64'h0, "R1 drop counter reset");

        // R10 routing entries
        wr(16'h8018, ent(1, 5, 0));
        wr(16'h8038, ent(1, 63, 1));
        wr(16'h8010, ent(0, 0, 0));
        rd(16'h8018, ent(1, 5, 0), "R10 entry 3 readback");
        rd(16'h8038, ent(1, 63, 1), "R10 entry 7 readback");

        // R2 / R3 enables
        wr(16'h1000, (64'd1 << 5) | (64'd1 << 9));
        rd(16'h1000, (64'd1 << 5) | (64'd1 << 9), "R2 enable set");
        wr(16'h1000, 64'd1 << 40);
        rd(16'h1008, (64'd1 << 5) | (64'd1 << 9) | (64'd1 << 40), "R2 zeros untouched");
        wr(16'h1008, (64'd1 << 9) | (64'd1 << 40));
        rd(16'h1000, 64'd1 << 5, "R3 enable clear");

        // R4 edge capture, R9 irq, R12 page isolation
        pulse(3);
        check(irq_out == 4'b0010, "R9 irq on enabled edge", 64'(irq_out), 64'h2);
        rd(16'h1018, 64'd1 << 5, "R4 edge sets bit");
        rd(16'h0018, 64'h0, "R12 other page untouched");
        rd(16'h1020, 64'd1 << 5, "R7 masked view");

        // R7 masked register ignores writes
        wr(16'h1020, '1);
        rd(16'h1018, 64'd1 << 5, "R7 write to masked ignored (status)");
        rd(16'h1000, 64'd1 << 5, "R7 write to masked ignored (enable)");

        // R5 clear by writing ones
        wr(16'h1018, 64'd1 << 4);
        rd(16'h1018, 64'd1 << 5, "R5 zero bit untouched");
        wr(16'h1018, 64'd1 << 5);
        rd(16'h1018, 64'h0, "R5 edge bit cleared");
        chk_irq(4'b0000, "R9 irq drops after clear");

        // R6 set and clear collide
        pulse(3);
        @(negedge clk);
        evt_in[3] = 1'b1;
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = 16'h1018; bus_wdata = 64'd1 << 5;
        @(negedge clk);
        evt_in[3] = 1'b0; bus_en = 1'b0; bus_we = 1'b0;
        rd(16'h1018, 64'd1 << 5, "R6 set wins over clear");
        wr(16'h1018, 64'd1 << 5);

        // R8 level slot
        @(negedge clk);
        evt_in[7] = 1'b1;
        rd(16'h1018, 64'd1 << 63, "R8 level follows high");
        pulse(3);
        wr(16'h1018, '1);
        rd(16'h1018, 64'd1 << 63, "R8 clear ignored on level");
        chk_irq(4'b0000, "R9 level bit not enabled");
        wr(16'h1000, 64'd1 << 63);
        chk_irq(4'b0010, "R9 level bit enabled");
        @(negedge clk);
        evt_in[7] = 1'b0;
        rd(16'h1018, 64'h0, "R8 level follows low");
        chk_irq(4'b0000, "R9 irq after level low");

        // R12 vint 0 page
        pulse(2);
        rd(16'h0018, 64'd1, "R12 vint0 status");
        rd(16'h1018, 64'h0, "R12 vint1 untouched");

        // R11 dropped events
        pulse(9); pulse(9); pulse(9);
        rd(16'hC000, 64'd3, "R11 drop count");
        wr(16'h8018, 64'h0);
        rd(16'h8018, 64'h0, "R10 unmap readback");
        pulse(3);
        rd(16'h1018, 64'h0, "R11 unmapped no status");
        rd(16'hC000, 64'd4, "R11 unmapped route counted");
        for (int i = 0; i < 300; i++) pulse(9);
        rd(16'hC000, 64'd255, "R11 drop counter saturates");

        // R13 no response after write
        wr(16'h2000, 64'h1);
        check(bus_rvalid == 1'b0, "R13 no rvalid after write", 64'(bus_rvalid), 64'h0);
        rd(16'h2000, 64'h1, "R12 vint2 page");
        @(negedge clk);
        check(sb.size() == 0, "R13 all reads answered", 64'(sb.size()), 64'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule